// File: doc/BRIEF.md
# Dual-Protocol Parallel Register Bus Slave

This block lets an external 8-bit microprocessor reach a bank of thirty-two 8-bit registers. Two static mode inputs choose the host style. `mode_intel` picks between the read/write-strobe style and the data-strobe plus direction style. `mode_mux` picks between a separate 5-bit address bus and a single 8-bit bus that carries the address first and the data after it. The bus pins are not treated as clocks. The block samples them on its own clock and finds strobes and edges from those samples. Bus timing is therefore modelled in whole clock cycles.

Reads drive the data bus only while a read cycle is active. A write is stored when its strobe ends. A completion handshake follows each strobe with a fixed delay. The top two addresses form an interrupt block. One is a status register whose bits are set by event pulses from the surrounding logic and cleared by writing 1. The other is an enable register. The interrupt output is high while any enabled status bit is set.

The data bus is split into `d_in`, `d_out` and an output enable `d_oe`. The pad ring combines these into the bidirectional pin.

Top module: `pbus_slave`

## Requirements
- R1: After reset, `d_oe`, `rdy_ack` and `irq_o` are 0, and every register reads back 0.
- R2: Strobe-pair style (`mode_intel`=1). `strb_n` acts as the read strobe and `dir` as the active-low write strobe. A read is active while `cs_n`=0, `strb_n`=0 and `dir`=1. A write is active while `cs_n`=0 and `dir`=0, and it is stored when that condition ends.
- R3: Data-strobe style (`mode_intel`=0). A cycle is active while `cs_n`=0 and `strb_n`=0. `dir`=1 selects a read and `dir`=0 selects a write. A write is stored when the cycle ends.
- R4: Multiplexed form (`mode_mux`=1). The address is taken from `d_in[4:0]` on a 1-to-0 transition of `ale_as`, and it is held for the following cycles. In this form `d_in[7:5]` and the `addr` input have no effect on the address. In the separate form (`mode_mux`=0) the address comes from `addr`.
- R5: `d_oe` is 1 only during an active read cycle. It rises one clock edge after the strobe is present at the pins and falls one clock edge after the strobe is removed. While `d_oe` is 1, `d_out` carries the addressed register.
- R6: `rdy_ack` rises on the second clock edge after a read or write strobe is applied. It falls on the second clock edge after the strobe is removed.
- R7: A stored write is returned by later reads of the same address. Strobes applied while `cs_n`=1 change no register.
- R8: Address 30 is the interrupt status register and address 31 is the interrupt enable register. Bit i of `irq_evt` being high on a clock edge sets status bit i. `irq_o` is 1 exactly when (status AND enable) is nonzero.
- R9: Writing status bit i with 1 clears it, and writing it with 0 leaves it unchanged. If an event and a clear hit the same bit on the same edge, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_mux | input | 1 | 1: multiplexed address/data bus; 0: separate address bus |
| mode_intel | input | 1 | 1: strobe-pair style; 0: data-strobe plus direction style |
| cs_n | input | 1 | Chip select, active low |
| strb_n | input | 1 | Read strobe (strobe-pair) or data strobe (data-strobe style), active low |
| dir | input | 1 | Active-low write strobe (strobe-pair) or read/not-write (data-strobe style) |
| ale_as | input | 1 | Address latch strobe; address taken on its falling transition |
| addr | input | 5 | Register address in the separate-bus form |
| d_in | input | 8 | Data bus input; also carries the address in the multiplexed form |
| d_out | output | 8 | Read data, valid while d_oe is 1 |
| d_oe | output | 1 | Data bus output enable |
| rdy_ack | output | 1 | Cycle completion handshake, active high |
| irq_evt | input | 8 | Interrupt event pulses, one per status bit |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A wrong latched address or a lost write does not show on its own. It appears as wrong `d_out` data on the next read of the affected address, which the scoreboard catches at the first clock where `rdy_ack` and `d_oe` are both high. A fault in the cycle decoder or the edge detector moves `d_oe` or `rdy_ack` off their expected edges. That is checked on the exact cycle in each style. A corrupted interrupt status register shows as a wrong `irq_o` level one edge after the event or the clearing write, and again as the value read back from address 30.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;

  // Classify one sample of the control pins for the selected host style.
  function automatic cyc_e classify(input logic intel, input logic cs_n,
                                    input logic strb_n, input logic dir);
    logic active;
    if (intel) active = !cs_n && (!strb_n || !dir);
    else       active = !cs_n && !strb_n;
    if (!active)  return CYC_IDLE;
    else if (dir) return CYC_READ;
    else          return CYC_WRITE;
  endfunction

endpackage

// File: rtl/pbus_sampler.sv
module pbus_sampler
  import pbus_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_mux,
  input  logic              mode_intel,
  input  logic              cs_n,
  input  logic              strb_n,
  input  logic              dir,
  input  logic              ale_as,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] d_in,
  output cyc_e              cur_cyc,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              commit_we,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data,
  output logic              ack
);

  logic              s_cs_n, s_strb_n, s_dir, s_ale;
  logic [ADDR_W-1:0] s_a;
  logic [DATA_W-1:0] s_d;
  logic              p_ale;
  logic [ADDR_W-1:0] p_a;
  logic [DATA_W-1:0] p_d;
  cyc_e              p_cyc;
  logic [ADDR_W-1:0] lat_q, lat_nxt;
  logic              lat_en;
  logic              ack_q, ack_nxt;

  // Next-state logic
  always_comb begin
    cur_cyc = classify(mode_intel, s_cs_n, s_strb_n, s_dir);
    lat_en  = mode_mux && p_ale && !s_ale;
    lat_nxt = s_d[ADDR_W-1:0];
    ack_nxt = (cur_cyc != CYC_IDLE);
  end

  // Pin sample stage and history stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cs_n   <= 1'b1;
      s_strb_n <= 1'b1;
      s_dir    <= 1'b1;
      s_ale    <= 1'b0;
      s_a      <= '0;
      s_d      <= '0;
      p_ale    <= 1'b0;
      p_a      <= '0;
      p_d      <= '0;
      p_cyc    <= CYC_IDLE;
      ack_q    <= 1'b0;
    end else begin
      s_cs_n   <= cs_n;
      s_strb_n <= strb_n;
      s_dir    <= dir;
      s_ale    <= ale_as;
      s_a      <= addr;
      s_d      <= d_in;
      p_ale    <= s_ale;
      p_a      <= s_a;
      p_d      <= s_d;
      p_cyc    <= cur_cyc;
      ack_q    <= ack_nxt;
    end
  end

  // Multiplexed address latch, clock-enabled on the latch strobe fall
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (lat_en) lat_q <= lat_nxt;
  end

  assign cur_addr    = mode_mux ? lat_q : s_a;
  assign commit_we   = (p_cyc == CYC_WRITE) && (cur_cyc != CYC_WRITE);
  assign commit_addr = mode_mux ? lat_q : p_a;
  assign commit_data = p_d;
  assign ack         = ack_q;

endmodule

// File: rtl/pbus_regfile.sv
module pbus_regfile #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] irq_evt,
  output logic              irq_o
);

  localparam int DEPTH     = 1 << ADDR_W;
  localparam int STAT_IDX  = DEPTH - 2;
  localparam int EN_IDX    = DEPTH - 1;
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_IDX);
  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_IDX);

  logic [DATA_W-1:0] mem [STAT_IDX];
  logic [DATA_W-1:0] stat_q, stat_nxt, en_q;
  logic [DATA_W-1:0] clr_mask;
  logic              plain_we, en_we;

  always_comb begin
    plain_we = we && (waddr < STAT_A);
    en_we    = we && (waddr == EN_A);
    clr_mask = (we && (waddr == STAT_A)) ? wdata : '0;
    stat_nxt = (stat_q & ~clr_mask) | irq_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAT_IDX; i++) mem[i] <= '0;
    end else if (plain_we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= stat_nxt;
      if (en_we) en_q <= wdata;
    end
  end

  always_comb begin
    if (raddr == STAT_A)    rdata = stat_q;
    else if (raddr == EN_A) rdata = en_q;
    else                    rdata = mem[raddr];
  end

  assign irq_o = |(stat_q & en_q);

endmodule

// File: rtl/pbus_slave.sv
module pbus_slave
  import pbus_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 8,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_mux,
  input  logic              mode_intel,
  input  logic              cs_n,
  input  logic              strb_n,
  input  logic              dir,
  input  logic              ale_as,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] d_in,
  output logic [DATA_W-1:0] d_out,
  output logic              d_oe,
  output logic              rdy_ack,
  input  logic [DATA_W-1:0] irq_evt,
  output logic              irq_o
);

  logic [RST_STAGES-1:0] rsync;
  logic                  rst_int_n;

  generate
    if (RST_STAGES == 1) begin : g_rs1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsync <= '0;
        else        rsync <= 1'b1;
      end
    end else begin : g_rsn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsync <= '0;
        else        rsync <= {rsync[RST_STAGES-2:0], 1'b1};
      end
    end
  endgenerate
  assign rst_int_n = rsync[RST_STAGES-1];

  cyc_e              cur_cyc;
  logic [ADDR_W-1:0] cur_addr, commit_addr;
  logic [DATA_W-1:0] commit_data, rdata;
  logic              commit_we;

  pbus_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
    .clk(clk), .rst_n(rst_int_n), .mode_mux(mode_mux), .mode_intel(mode_intel),
    .cs_n(cs_n), .strb_n(strb_n), .dir(dir), .ale_as(ale_as), .addr(addr),
    .d_in(d_in), .cur_cyc(cur_cyc), .cur_addr(cur_addr), .commit_we(commit_we),
    .commit_addr(commit_addr), .commit_data(commit_data), .ack(rdy_ack)
  );

  pbus_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst_n(rst_int_n), .we(commit_we), .waddr(commit_addr),
    .wdata(commit_data), .raddr(cur_addr), .rdata(rdata),
    .irq_evt(irq_evt), .irq_o(irq_o)
  );

  assign d_oe  = (cur_cyc == CYC_READ);
  assign d_out = d_oe ? rdata : '0;

endmodule

// File: rtl/pbus_slave_chk.sv
module pbus_slave_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              d_oe,
  input logic              rdy_ack,
  input logic [DATA_W-1:0] irq_evt,
  input logic              irq_o
);

  // R5
  oe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> !$past(cs_n));

  // R6
  ack_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_ack |-> !$past(cs_n, 2));

  // R6
  ack_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_oe && $past(d_oe)) |-> rdy_ack);

  // R8
  irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(|irq_evt) || $past(rdy_ack)));

endmodule

bind pbus_slave pbus_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .d_oe(d_oe),
  .rdy_ack(rdy_ack), .irq_evt(irq_evt), .irq_o(irq_o)
);

// File: tb/test_pbus_slave.sv
module test_pbus_slave;

  logic       clk = 1'b0;
  logic       rst_n, mode_mux, mode_intel, cs_n, strb_n, dir, ale_as;
  logic [4:0] addr;
  logic [7:0] d_in, d_out, irq_evt;
  logic       d_oe, rdy_ack, irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         mon_busy = 1'b0;

  always #5 clk = ~clk;

  pbus_slave i_pbus_slave (
    .clk(clk), .rst_n(rst_n), .mode_mux(mode_mux), .mode_intel(mode_intel),
    .cs_n(cs_n), .strb_n(strb_n), .dir(dir), .ale_as(ale_as), .addr(addr),
    .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .rdy_ack(rdy_ack),
    .irq_evt(irq_evt), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: one comparison per read cycle, taken once the handshake is up
  always @(negedge clk) begin
    if (rdy_ack && d_oe) begin
      if (!mon_busy) begin
        mon_busy = 1'b1;
        if (exp_q.size() == 0) chk("R5 unexpected read data", d_out, 8'hxx);
        else chk(tag_q.pop_front(), d_out, exp_q.pop_front());
      end
    end else if (!rdy_ack) begin
      mon_busy = 1'b0;
    end
  end

  task automatic do_reset(input logic mux, input logic intel);
    rst_n = 1'b0; mode_mux = mux; mode_intel = intel;
    cs_n = 1'b1; strb_n = 1'b1; dir = 1'b1; ale_as = 1'b0;
    addr = '0; d_in = '0; irq_evt = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic addr_phase(input logic [4:0] ad);
    if (mode_mux) begin
      addr = ~ad;
      d_in = {3'b101, ad};
      ale_as = 1'b1; @(negedge clk);
      ale_as = 1'b0; @(negedge clk);
      @(negedge clk);
    end else begin
      addr = ad;
    end
  endtask

  task automatic bus_wr(input logic [4:0] ad, input logic [7:0] data);
    addr_phase(ad);
    d_in = data; cs_n = 1'b0; dir = 1'b0;
    if (!mode_intel) strb_n = 1'b0;
    repeat (3) @(negedge clk);
    if (mode_intel) dir = 1'b1; else strb_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; dir = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_rd(input logic [4:0] ad, input logic [7:0] exp, input string tag);
    addr_phase(ad);
    exp_q.push_back(exp); tag_q.push_back(tag);
    d_in = 8'h5A; cs_n = 1'b0; dir = 1'b1; strb_n = 1'b0;
    repeat (3) @(negedge clk);
    strb_n = 1'b1; @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // Strobe-pair style, separate buses
    do_reset(1'b0, 1'b1);
    chk("R1 d_oe after reset", {7'd0, d_oe}, 8'h00);
    chk("R1 rdy_ack after reset", {7'd0, rdy_ack}, 8'h00);
    chk("R1 irq_o after reset", {7'd0, irq_o}, 8'h00);
    bus_rd(5'd3, 8'h00, "R1 register reset value");
    bus_wr(5'd3, 8'hA5);
    bus_wr(5'd17, 8'h3C);
    bus_rd(5'd3, 8'hA5, "R2 read back addr 3");
    bus_rd(5'd17, 8'h3C, "R2 read back addr 17");

    // R5 R6: exact edges of d_oe and rdy_ack
    addr = 5'd17;
    exp_q.push_back(8'h3C); tag_q.push_back("R5 data at handshake");
    cs_n = 1'b0; strb_n = 1'b0; dir = 1'b1;
    @(negedge clk);
    chk("R5 d_oe one edge after strobe", {7'd0, d_oe}, 8'h01);
    chk("R6 rdy_ack still low", {7'd0, rdy_ack}, 8'h00);
    @(negedge clk);
    chk("R6 rdy_ack two edges after strobe", {7'd0, rdy_ack}, 8'h01);
    strb_n = 1'b1;
    @(negedge clk);
    chk("R5 d_oe drops one edge after release", {7'd0, d_oe}, 8'h00);
    chk("R6 rdy_ack held one edge", {7'd0, rdy_ack}, 8'h01);
    @(negedge clk);
    chk("R6 rdy_ack drops second edge", {7'd0, rdy_ack}, 8'h00);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7: strobes without chip select are ignored
    addr = 5'd3; d_in = 8'hFF; dir = 1'b0; strb_n = 1'b0;
    repeat (3) @(negedge clk);
    dir = 1'b1; strb_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 no ack without select", {7'd0, rdy_ack}, 8'h00);
    bus_rd(5'd3, 8'hA5, "R7 unselected write ignored");

    // Interrupt block R8 R9
    bus_wr(5'd31, 8'h05);
    irq_evt = 8'h02; @(negedge clk); irq_evt = 8'h00; @(negedge clk);
    chk("R8 masked event keeps irq low", {7'd0, irq_o}, 8'h00);
    irq_evt = 8'h04; @(negedge clk); irq_evt = 8'h00;
    chk("R8 enabled event raises irq", {7'd0, irq_o}, 8'h01);
    bus_rd(5'd30, 8'h06, "R8 status read");
    bus_rd(5'd31, 8'h05, "R8 enable read");
    bus_wr(5'd30, 8'h04);
    chk("R9 clear drops irq", {7'd0, irq_o}, 8'h00);
    bus_rd(5'd30, 8'h02, "R9 write 0 keeps other bit");
    irq_evt = 8'h01;
    bus_wr(5'd30, 8'h01);
    chk("R9 event beats clear", {7'd0, irq_o}, 8'h01);
    irq_evt = 8'h00;
    bus_wr(5'd30, 8'h03);
    bus_rd(5'd30, 8'h00, "R9 status cleared");
    chk("R9 irq low after clear", {7'd0, irq_o}, 8'h00);

    // Data-strobe style, separate buses
    do_reset(1'b0, 1'b0);
    bus_rd(5'd3, 8'h00, "R1 reset clears data-strobe run");
    bus_wr(5'd9, 8'h81);
    bus_wr(5'd0, 8'h7E);
    bus_rd(5'd9, 8'h81, "R3 data-strobe read addr 9");
    bus_rd(5'd0, 8'h7E, "R3 data-strobe read addr 0");

    // Multiplexed strobe-pair
    do_reset(1'b1, 1'b1);
    bus_wr(5'd21, 8'hC3);
    bus_wr(5'd29, 8'h11);
    bus_rd(5'd21, 8'hC3, "R4 mux strobe-pair addr 21");
    bus_rd(5'd29, 8'h11, "R4 mux strobe-pair addr 29");

    // Multiplexed data-strobe: latched address reused without a new latch
    do_reset(1'b1, 1'b0);
    bus_wr(5'd6, 8'h42);
    bus_rd(5'd6, 8'h42, "R4 mux data-strobe addr 6");
    bus_wr(5'd12, 8'h99);
    addr = 5'd6;
    exp_q.push_back(8'h99); tag_q.push_back("R4 held address ignores addr pins");
    cs_n = 1'b0; dir = 1'b1; strb_n = 1'b0;
    repeat (3) @(negedge clk);
    strb_n = 1'b1; @(negedge clk); cs_n = 1'b1;
    repeat (2) @(negedge clk);

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) chk("R5 reads without data", 8'(exp_q.size()), 8'h00);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule